// File: doc/BRIEF.md
# Coprocessor Unit Clock-Enable Generator

This block decides, every cycle, whether the clock of the SIMD/floating-point coprocessor unit and the clock of the trace unit may run. It keeps a small set of control bits: one access field for each coprocessor number that the unit serves, a unit enable bit and a trace global enable bit. Software-visible logic elsewhere writes these bits through a plain write port. The block combines them with a pipeline occupancy count that the issue logic supplies.

The coprocessor clock may run only when three things hold: every access field grants access, the unit enable bit is set, and instructions for the unit are in flight. A short tail after the pipeline drains stops the enable from toggling between back-to-back instructions. The trace enable follows the trace global enable bit alone. The trace bus clock is not handled here. Both enables come straight from flops, so they can drive a latch-based clock-gate cell directly. Reset turns both gates off.

Top module: `coproc_clken`

## Requirements
- R1: While reset is asserted and after it is released, all control bits read as zero and both `simd_clk_en` and `trace_clk_en` are low.
- R2: A write (`wr_en` high) is sampled at a rising clock edge. Address 0 loads the access fields: field 0 from `wr_data[1:0]` and field 1 from `wr_data[3:2]`. Address 1 loads the unit enable from `wr_data[0]`. Address 2 loads the trace global enable from `wr_data[0]`. The outputs show the new value at the edge after the write edge.
- R3: Access is granted only when every access field is nonzero, and any nonzero 2-bit value grants. With either field zero, `simd_clk_en` stays low whatever the occupancy.
- R4: When the unit enable bit is clear, `simd_clk_en` is low regardless of the access fields and the occupancy.
- R5: With access granted and the unit enabled, `simd_clk_en` goes high at the first rising edge that samples a nonzero `occ_count`.
- R6: After `occ_count` returns to zero, `simd_clk_en` stays high for HOLD_CYCLES (default 1) more edges and then goes low. A single zero cycle between two busy cycles therefore keeps it high without a break.
- R7: If the grant is lost while instructions are in flight, `simd_clk_en` goes low at the next edge, with no tail.
- R8: `trace_clk_en` follows the trace global enable bit. The access fields, the unit enable and the occupancy have no effect on it.
- R9: A write to address 3 changes none of the control bits, and neither enable changes because of it.
- R10: Both enables change only at a rising clock edge. An input change between edges does not show on them before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-register write strobe |
| wr_addr | input | 2 | Control-register select (0 access, 1 unit enable, 2 trace enable, 3 unused) |
| wr_data | input | DATA_W | Write data |
| occ_count | input | OCC_W | Number of coprocessor instructions in flight |
| simd_clk_en | output | 1 | Registered clock enable for the SIMD/floating-point unit |
| trace_clk_en | output | 1 | Registered clock enable for the trace unit |

## Verification
An occupancy change driven between edges appears on `simd_clk_en` right after the next rising edge. The drain tail lasts one further edge. A control write takes two edges to reach either enable: one to load the register and one to load the output flop. The bench drives every input on the falling edge and counts falling edges to the cycle where each result is due, then samples there. The registered-output check also samples one nanosecond after an input change, before any rising edge, to confirm that nothing has moved yet.

// File: rtl/clken_pkg.sv
package clken_pkg;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_ACCESS = 2'd0,
      SEL_UNIT   = 2'd1,
      SEL_TRACE  = 2'd2,
      SEL_SPARE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/clken_regs.sv
module clken_regs
   import clken_pkg::*;
#(
   parameter int NUM_ACC      = 2,
   parameter int ACC_W        = 2,
   parameter int DATA_W       = 8,
   parameter int UNIT_EN_BIT  = 0,
   parameter int TRACE_EN_BIT = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [NUM_ACC*ACC_W-1:0] acc_o,
   output logic                     unit_en_o,
   output logic                     trace_en_o
);
   localparam int ACC_TOT = NUM_ACC * ACC_W;

   logic [ACC_TOT-1:0] acc_q;
   logic               unit_q;
   logic               trace_q;
   reg_sel_e           sel;
   logic               unused_wr_bits;

   assign sel            = reg_sel_e'(wr_addr);
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         unit_q  <= 1'b0;
         trace_q <= 1'b0;
      end else if (wr_en) begin
         case (sel)
            SEL_ACCESS: acc_q   <= wr_data[ACC_TOT-1:0];
            SEL_UNIT:   unit_q  <= wr_data[UNIT_EN_BIT];
            SEL_TRACE:  trace_q <= wr_data[TRACE_EN_BIT];
            default:    ;
         endcase
      end
   end

   assign acc_o      = acc_q;
   assign unit_en_o  = unit_q;
   assign trace_en_o = trace_q;

   // R9
   spare_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SEL_SPARE) |=> ($stable(acc_q) && $stable(unit_q) && $stable(trace_q)));
endmodule

// File: rtl/clken_grant.sv
module clken_grant #(
   parameter int NUM_ACC = 2,
   parameter int ACC_W   = 2
) (
   input  logic [NUM_ACC*ACC_W-1:0] acc_i,
   input  logic                     unit_en_i,
   output logic                     grant_o
);
   logic [NUM_ACC-1:0] field_ok;

   for (genvar i = 0; i < NUM_ACC; i++) begin : g_field
      assign field_ok[i] = |acc_i[i*ACC_W +: ACC_W];
   end

   assign grant_o = unit_en_i & (&field_ok);
endmodule

// File: rtl/clken_occupancy.sv
module clken_occupancy #(
   parameter int OCC_W       = 4,
   parameter int HOLD_CYCLES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occ_i,
   output logic             active_o
);
   logic busy;
   assign busy = |occ_i;

   if (HOLD_CYCLES == 0) begin : g_no_tail
      assign active_o = busy;
   end else begin : g_tail
      localparam int HW = $clog2(HOLD_CYCLES + 1);
      logic [HW-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hold_q <= '0;
         else if (busy)
            hold_q <= HW'(HOLD_CYCLES);
         else if (hold_q != '0)
            hold_q <= hold_q - HW'(1);
      end

      assign active_o = busy | (|hold_q);

      // R6
      drain_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(busy) |-> active_o);
   end
endmodule

// File: rtl/clken_outreg.sv
module clken_outreg (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_i,
   input  logic active_i,
   input  logic trace_i,
   output logic simd_en_o,
   output logic trace_en_o
);
   logic simd_q;
   logic trace_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         simd_q  <= 1'b0;
         trace_q <= 1'b0;
      end else begin
         simd_q  <= grant_i & active_i;
         trace_q <= trace_i;
      end
   end

   assign simd_en_o  = simd_q;
   assign trace_en_o = trace_q;

   // R3
   simd_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      simd_q |-> $past(grant_i));

   // R5
   simd_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(simd_q) |-> $past(active_i));

   // R7
   simd_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(simd_q) |-> (!$past(grant_i) || !$past(active_i)));

   // R8
   trace_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trace_q) |-> $past(trace_i));
endmodule

// File: rtl/coproc_clken.sv
module coproc_clken
   import clken_pkg::*;
#(
   parameter int NUM_ACC      = 2,
   parameter int ACC_W        = 2,
   parameter int DATA_W       = 8,
   parameter int OCC_W        = 4,
   parameter int HOLD_CYCLES  = 1,
   parameter int UNIT_EN_BIT  = 0,
   parameter int TRACE_EN_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [OCC_W-1:0]  occ_count,
   output logic              simd_clk_en,
   output logic              trace_clk_en
);
   localparam int ACC_TOT = NUM_ACC * ACC_W;

   if (NUM_ACC < 1 || ACC_W < 1) begin : g_bad_fields
      $error("coproc_clken: NUM_ACC and ACC_W must be at least 1");
   end
   if (ACC_TOT > DATA_W) begin : g_bad_width
      $error("coproc_clken: access fields do not fit in DATA_W");
   end
   if (UNIT_EN_BIT >= DATA_W || TRACE_EN_BIT >= DATA_W) begin : g_bad_bit
      $error("coproc_clken: enable bit position outside DATA_W");
   end
   if (OCC_W < 1 || HOLD_CYCLES < 0 || HOLD_CYCLES > 255) begin : g_bad_occ
      $error("coproc_clken: OCC_W or HOLD_CYCLES out of range");
   end

   logic [ACC_TOT-1:0] acc;
   logic               unit_en;
   logic               trace_bit;
   logic               grant;
   logic               active;

   clken_regs #(
      .NUM_ACC(NUM_ACC), .ACC_W(ACC_W), .DATA_W(DATA_W),
      .UNIT_EN_BIT(UNIT_EN_BIT), .TRACE_EN_BIT(TRACE_EN_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .acc_o(acc), .unit_en_o(unit_en), .trace_en_o(trace_bit)
   );

   clken_grant #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W)) u_grant (
      .acc_i(acc), .unit_en_i(unit_en), .grant_o(grant)
   );

   clken_occupancy #(.OCC_W(OCC_W), .HOLD_CYCLES(HOLD_CYCLES)) u_occ (
      .clk(clk), .rst_n(rst_n), .occ_i(occ_count), .active_o(active)
   );

   clken_outreg u_out (
      .clk(clk), .rst_n(rst_n), .grant_i(grant), .active_i(active),
      .trace_i(trace_bit), .simd_en_o(simd_clk_en), .trace_en_o(trace_clk_en)
   );

   // R4
   unit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      simd_clk_en |-> $past(unit_en));
endmodule

// File: tb/tb_coproc_clken.sv
`timescale 1ns/1ps
module tb_coproc_clken;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] occ_count = '0;
   logic       simd_clk_en;
   logic       trace_clk_en;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   coproc_clken dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .occ_count(occ_count),
      .simd_clk_en(simd_clk_en), .trace_clk_en(trace_clk_en)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // write sampled at next rising edge; returns after the edge where outputs reflect it
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 simd after reset", simd_clk_en, 1'b0);
      check("R1 trace after reset", trace_clk_en, 1'b0);
      rst_n = 1'b1;
      occ_count = 4'd3;
      @(negedge clk); @(negedge clk);
      check("R1 simd stays off, fields clear", simd_clk_en, 1'b0);
      check("R1 trace stays off", trace_clk_en, 1'b0);
   endtask

   task automatic t_access();
      wr(2'd1, 8'h01);
      occ_count = 4'd3;
      wr(2'd0, 8'h01);            // field0=1, field1=0
      check("R3 field1 zero blocks", simd_clk_en, 1'b0);
      wr(2'd0, 8'h04);            // field0=0, field1=1
      check("R3 field0 zero blocks", simd_clk_en, 1'b0);
      wr(2'd0, 8'h09);            // field0=1, field1=2
      check("R3 nonzero fields grant", simd_clk_en, 1'b1);
      wr(2'd0, 8'h0F);
      check("R3 value 3 grants", simd_clk_en, 1'b1);
   endtask

   task automatic t_unit_off();
      wr(2'd1, 8'h00);
      check("R4 unit bit clear forces off", simd_clk_en, 1'b0);
      wr(2'd1, 8'h01);
      check("R4 unit bit set restores", simd_clk_en, 1'b1);
   endtask

   task automatic t_rise_fall();
      occ_count = 4'd0;
      @(negedge clk); @(negedge clk);
      check("R6 idle after drain", simd_clk_en, 1'b0);
      occ_count = 4'd1;
      #1;
      check("R10 no change before edge", simd_clk_en, 1'b0);
      @(negedge clk);
      check("R5 rises at first busy edge", simd_clk_en, 1'b1);
      occ_count = 4'd0;
      @(negedge clk);
      check("R6 tail edge", simd_clk_en, 1'b1);
      @(negedge clk);
      check("R6 low after tail", simd_clk_en, 1'b0);
   endtask

   task automatic t_back_to_back();
      occ_count = 4'd1;
      @(negedge clk);
      check("R5 busy", simd_clk_en, 1'b1);
      occ_count = 4'd0;
      @(negedge clk);
      check("R6 gap cycle held", simd_clk_en, 1'b1);
      occ_count = 4'd2;
      @(negedge clk);
      check("R6 second burst continuous", simd_clk_en, 1'b1);
      occ_count = 4'd0;
      @(negedge clk);
      check("R6 tail after second burst", simd_clk_en, 1'b1);
      @(negedge clk);
      check("R6 off after second burst", simd_clk_en, 1'b0);
   endtask

   task automatic t_grant_loss();
      occ_count = 4'd2;
      @(negedge clk);
      check("R5 busy before revoke", simd_clk_en, 1'b1);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h0C;   // field0=0
      @(negedge clk);
      wr_en = 1'b0;
      check("R2 old grant still seen one edge", simd_clk_en, 1'b1);
      @(negedge clk);
      check("R7 off with no tail", simd_clk_en, 1'b0);
   endtask

   task automatic t_trace();
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
      @(negedge clk);
      wr_en = 1'b0;
      check("R2 trace not yet visible", trace_clk_en, 1'b0);
      @(negedge clk);
      check("R8 trace on from bit", trace_clk_en, 1'b1);
      occ_count = 4'd0;
      wr(2'd1, 8'h00);
      check("R8 trace unaffected by unit bit and occupancy", trace_clk_en, 1'b1);
      check("R8 simd off meanwhile", simd_clk_en, 1'b0);
      wr(2'd2, 8'h00);
      check("R8 trace off", trace_clk_en, 1'b0);
   endtask

   task automatic t_spare();
      wr(2'd1, 8'h01);
      wr(2'd0, 8'h01);            // field1 zero: no grant
      occ_count = 4'd1;
      wr(2'd3, 8'hFF);
      @(negedge clk);
      check("R9 spare write leaves access", simd_clk_en, 1'b0);
      check("R9 spare write leaves trace", trace_clk_en, 1'b0);
      wr(2'd0, 8'h05);
      check("R9 unit bit still set after spare write", simd_clk_en, 1'b1);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      t_reset();
      t_access();
      t_unit_off();
      t_rise_fall();
      t_back_to_back();
      t_grant_loss();
      t_trace();
      t_spare();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule